// File: doc/BRIEF.md
# Packed Signed 16-bit Lane Multiplier

This block multiplies two 128-bit operands lane by lane. Each operand is read as eight signed 16-bit lanes, and every pair of matching lanes produces a full 32-bit two's-complement product. A two-bit mode input selects how the eight products are packed into the 128-bit result. The result can be the low halves of the products, the high halves, or four 32-bit sums of neighbouring product pairs. The last form serves filter taps and transform butterflies, because one operation both widens and reduces the products.

The datapath is a fixed two-stage pipeline with no stall input. The first stage registers the eight products along with the mode and the valid flag. The second stage formats the products and registers the result. A result leaves exactly two clock edges after its operands were accepted, and a new operand set can be accepted on every cycle. The result register keeps its value through cycles that carry no valid data.

Top module: `packed_mul_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` = 0 and `out_data` = 0.
- R2: Mode code 0 (low): result lane i (bits 16i+15:16i) holds bits 15:0 of the signed product of operand lanes i (bits 16i+15:16i of `opa` and `opb`).
- R3: Mode code 1 (high): result lane i holds bits 31:16 of the signed product of operand lanes i, so -32768 × -32768 gives 0x4000.
- R4: Mode code 2 (pair sum): 32-bit result lane k (bits 32k+31:32k) holds the sum of the signed products of lanes 2k and 2k+1, wrapped modulo 2^32, for k = 0 to 3.
- R5: In mode code 2, when both operands hold -32768 in lanes 2k and 2k+1, result lane k is 0x80000000.
- R6: Mode code 3 is reserved and gives an all-zero result.
- R7: `out_valid` equals `in_valid` from two clock edges earlier, and a valid set is accepted on every cycle, back to back.
- R8: After a cycle in which `in_valid` was low, `out_data` keeps its previous value when that slot reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode_in | input | 2 | 0 low, 1 high, 2 pair sum, 3 reserved |
| opa | input | 128 | First operand, eight signed 16-bit lanes |
| opb | input | 128 | Second operand, eight signed 16-bit lanes |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_data | output | 128 | Packed result |

## Verification
The bench builds the block with its default parameters: eight lanes of 16 bits. With that width every lane position and every one of the four pair sums is observed, and the extreme lane values -32768 and 32767 reach the wrap case of the pair sum and the sign of the high half. Random operands are biased toward these extreme values and toward zero. The random valid pattern produces gaps that check the hold of the result and back-to-back operand sets that check the two-cycle latency.

// File: rtl/packed_mul_pkg.sv
package packed_mul_pkg;

    typedef enum logic [1:0] {
        PM_LOW  = 2'd0,
        PM_HIGH = 2'd1,
        PM_PAIR = 2'd2,
        PM_RSVD = 2'd3
    } pm_mode_e;

endpackage

// File: rtl/packed_mul_lane.sv
module packed_mul_lane #(
    parameter int LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [LANE_W-1:0]     a,
    input  logic [LANE_W-1:0]     b,
    output logic [2*LANE_W-1:0]   prod
);
    localparam int PW = 2 * LANE_W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] p_full;

    always_comb begin
        a_ext  = PW'($signed(a));
        b_ext  = PW'($signed(b));
        p_full = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else if (en) begin
            prod <= p_full;
        end
    end
endmodule

// File: rtl/packed_mul_pair_fmt.sv
module packed_mul_pair_fmt
    import packed_mul_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  pm_mode_e              mode,
    input  logic [2*LANE_W-1:0]   p_even,
    input  logic [2*LANE_W-1:0]   p_odd,
    output logic [2*LANE_W-1:0]   slice
);
    always_comb begin
        unique case (mode)
            PM_LOW:  slice = {p_odd[LANE_W-1:0], p_even[LANE_W-1:0]};
            PM_HIGH: slice = {p_odd[2*LANE_W-1:LANE_W], p_even[2*LANE_W-1:LANE_W]};
            PM_PAIR: slice = p_even + p_odd;
            PM_RSVD: slice = '0;
        endcase
    end
endmodule

// File: rtl/packed_mul_unit.sv
module packed_mul_unit
    import packed_mul_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [1:0]                mode_in,
    input  logic [LANES*LANE_W-1:0]   opa,
    input  logic [LANES*LANE_W-1:0]   opb,
    output logic                      out_valid,
    output logic [LANES*LANE_W-1:0]   out_data
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int PROD_W = 2 * LANE_W;
    localparam int PAIRS  = LANES / 2;

    logic                  s1_valid;
    pm_mode_e              s1_mode;
    logic [PROD_W-1:0]     s1_prod [LANES];
    logic [DATA_W-1:0]     fmt_data;

    // Stage 1: lane products
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        packed_mul_lane #(.LANE_W(LANE_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .en   (in_valid),
            .a    (opa[i*LANE_W +: LANE_W]),
            .b    (opb[i*LANE_W +: LANE_W]),
            .prod (s1_prod[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_mode  <= PM_LOW;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= pm_mode_e'(mode_in);
            end
        end
    end

    // Stage 2: packing per pair of lanes
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        packed_mul_pair_fmt #(.LANE_W(LANE_W)) u_fmt (
            .mode   (s1_mode),
            .p_even (s1_prod[2*k]),
            .p_odd  (s1_prod[2*k+1]),
            .slice  (fmt_data[k*PROD_W +: PROD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= fmt_data;
            end
        end
    end
endmodule

// File: rtl/packed_mul_unit_chk.sv
module packed_mul_unit_chk #(
    parameter int LANE_W = 16,
    parameter int LANES  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [1:0]               mode_in,
    input logic [2*LANE_W-1:0]      opa_lo,
    input logic [2*LANE_W-1:0]      opb_lo,
    input logic                     out_valid,
    input logic [LANES*LANE_W-1:0]  out_data
);
    localparam int PW = 2 * LANE_W;
    localparam logic [PW-1:0] MIN_PAIR = {1'b1, {(LANE_W-1){1'b0}}, 1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [PW-1:0] WRAP_SUM = {1'b1, {(PW-1){1'b0}}};

    logic          v1, v2;
    logic [1:0]    m1, m2;
    logic [PW-1:0] a1, a2, b1, b2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            m1 <= '0;   m2 <= '0;
            a1 <= '0;   a2 <= '0;
            b1 <= '0;   b2 <= '0;
        end else begin
            v1 <= in_valid; v2 <= v1;
            m1 <= mode_in;  m2 <= m1;
            a1 <= opa_lo;   a2 <= a1;
            b1 <= opb_lo;   b2 <= b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    a_r7_two_cycle_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && m2 == 2'd3) |-> out_data == '0);

    a_r5_pair_wrap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && m2 == 2'd2 && a2 == MIN_PAIR && b2 == MIN_PAIR)
            |-> out_data[PW-1:0] == WRAP_SUM);
endmodule

bind packed_mul_unit packed_mul_unit_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode_in   (mode_in),
    .opa_lo    (opa[2*LANE_W-1:0]),
    .opb_lo    (opb[2*LANE_W-1:0]),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/packed_mul_unit_test.sv
`timescale 1ns/1ps
module packed_mul_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode_in = 2'd0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model pipeline
    logic         e1_v = 1'b0, e2_v = 1'b0;
    logic [127:0] e1_d = '0,   e2_d = '0;
    string        e1_t = "R7", e2_t = "R7";

    always #2 clk = ~clk;

    packed_mul_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_in(mode_in),
        .opa(opa), .opb(opb), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [127:0] ref_out(logic [127:0] a, logic [127:0] b, logic [1:0] m);
        logic [127:0] r = '0;
        int p [8];
        for (int i = 0; i < 8; i++) begin
            int x, y;
            x = $signed(a[i*16 +: 16]);
            y = $signed(b[i*16 +: 16]);
            p[i] = x * y;
        end
        for (int i = 0; i < 8; i++) begin
            if (m == 2'd0) r[i*16 +: 16] = p[i][15:0];
            if (m == 2'd1) r[i*16 +: 16] = p[i][31:16];
        end
        if (m == 2'd2)
            for (int k = 0; k < 4; k++) r[k*32 +: 32] = p[2*k] + p[2*k+1];
        return r;
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [15:0] pick_lane();
        case ($urandom % 6)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive, clock, compare at the falling edge
    task automatic step(logic v, logic [1:0] m, logic [127:0] a, logic [127:0] b, string tag);
        in_valid = v; mode_in = m; opa = a; opb = b;
        @(posedge clk);
        e2_v = e1_v;
        if (e1_v) begin e2_d = e1_d; e2_t = e1_t; end
        e1_v = v;
        e1_d = ref_out(a, b, m);
        e1_t = (tag != "") ? tag : mode_tag(m);
        @(negedge clk);
        check("R7 out_valid", {127'd0, out_valid}, {127'd0, e2_v});
        if (e2_v) check(e2_t, out_data, e2_d);
        else      check("R8 hold", out_data, e2_d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] mn, mx;
        void'($urandom(32'd20240611));
        mn = {8{16'h8000}};
        mx = {8{16'h7FFF}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 out_valid", {127'd0, out_valid}, 128'd0);
        check("R1 out_data", out_data, 128'd0);

        // directed corners
        step(1'b1, 2'd2, mn, mn, "R5");
        step(1'b1, 2'd1, mn, mn, "R3");
        step(1'b1, 2'd0, mn, mn, "R2");
        step(1'b1, 2'd2, mx, mx, "R4");
        step(1'b1, 2'd1, mx, mn, "R3");
        step(1'b1, 2'd3, mx, mx, "R6");
        step(1'b0, 2'd2, mx, mn, "");
        step(1'b0, 2'd1, '0, '0, "");
        step(1'b1, 2'd0, 128'h0001_0002_0003_0004_FFFF_FFFE_7FFF_8000,
                         128'h0005_0006_FFF9_0008_0003_FFFE_0002_0001, "R2");
        step(1'b0, 2'd0, '0, '0, "");
        step(1'b0, 2'd0, '0, '0, "");

        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [127:0] ra, rb;
            for (int i = 0; i < 8; i++) begin
                ra[i*16 +: 16] = pick_lane();
                rb[i*16 +: 16] = pick_lane();
            end
            step(($urandom % 4) != 0, 2'($urandom % 4), ra, rb, "");
        end
        step(1'b0, 2'd0, '0, '0, "");
        step(1'b0, 2'd0, '0, '0, "");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule